// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block converts a 32-bit virtual address into a physical address by reading two levels of page table held in ordinary memory. Each request carries a virtual address and the frame number of the top-level table. The walker reads one top-level entry. The frame number in that entry locates a second-level table. It reads one entry there, and the frame number in that entry, joined with the untouched page offset, is the physical address. If either entry is marked not present, the walk ends with a page fault that reports the level where it stopped.

Memory is reached through a simple word-read port. The walker raises a read request with an address and holds it until the memory accepts it. The memory then returns one data word, a cycle or many cycles later. Because the second read depends on the data of the first, the walker runs as a multi-cycle state machine. It accepts a new request only when it is idle.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and both `mem_req_valid` and `done_valid` are 0.
- R2: The first read address is the table base frame shifted left by 12, plus 4 times virtual address bits 31:22.
- R3: The second read address is the frame field of the first entry (bits 31:12) shifted left by 12, plus 4 times virtual address bits 21:12.
- R4: When both entries have the present bit (bit 0) set, the result has `done_fault` = 0 and `done_level` = 0. `done_paddr` is the second entry's bits 31:12 above virtual address bits 11:0. Entry bits 11:1 have no effect.
- R5: A first-level entry with bit 0 clear ends the walk with `done_fault` = 1 and `done_level` = 0, and no second read is issued.
- R6: A second-level entry with bit 0 clear ends the walk with `done_fault` = 1 and `done_level` = 1.
- R7: `req_ready` is 1 only while idle. A request raised while a walk is in progress is ignored and does not alter that walk's result.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays raised and its address stays unchanged in the next cycle.
- R9: `done_valid` is a single-cycle pulse in the cycle after the final (or faulting) response is sampled. Any response latency is accepted, and exactly one result is produced per accepted request.
- R10: With table base frame 0x00010, virtual address 0x00403004 reads top-level entry 1 (address 0x00010004), then entry 3 of the selected second-level table, and keeps offset 0x004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | High when idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 20 | Frame number of the top-level table, sampled at accept |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid (one pulse per accepted read) |
| mem_rsp_data | input | 32 | Entry word: frame in 31:12, present flag in bit 0 |
| done_valid | output | 1 | One-cycle result strobe |
| done_paddr | output | 32 | Translated physical address (meaningful when no fault) |
| done_fault | output | 1 | Walk ended on a non-present entry |
| done_level | output | 1 | Level of the fault: 0 top, 1 second |

## Verification
Each result has a known timing. The first read request appears in the cycle after accept and stays raised until the memory takes it. The second request follows one cycle after the first response. The result pulse arrives exactly one cycle after the last response is sampled. The bench memory model varies both the accept stall (0 to 2 cycles) and the response delay (0 to 3 cycles), and it compares each read address with the expected address as the read is taken. Inputs are driven and outputs sampled on falling edges. The monitor pops an expected result only on the `done_valid` strobe, so an early, late, doubled or missing result shows up as a mismatch or a leftover entry.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  // Walk sequencing states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_WT1,
    ST_RD2,
    ST_WT2,
    ST_FIN
  } walk_state_e;

  localparam int LEVELS = 2;

endpackage

// File: rtl/pt_entry_addr.sv
// Byte address of one table entry: table frame base plus scaled index.
module pt_entry_addr #(
  parameter int FRAME_W  = 20,
  parameter int IDX_W    = 10,
  parameter int OFF_W    = 12,
  parameter int ENT_LOG2 = 2
) (
  input  logic [FRAME_W-1:0]       frame_i,
  input  logic [IDX_W-1:0]         idx_i,
  output logic [FRAME_W+OFF_W-1:0] addr_o
);
  localparam int PA_W   = FRAME_W + OFF_W;
  localparam int SCL_W  = IDX_W + ENT_LOG2;

  logic [SCL_W-1:0] scaled;

  assign scaled = {idx_i, {ENT_LOG2{1'b0}}};
  assign addr_o = {frame_i, {OFF_W{1'b0}}} + PA_W'(scaled);

endmodule

// File: rtl/pt_walk_fsm.sv
// Sequencer: issues reads, interprets returned entries, holds the outcome.
module pt_walk_fsm
  import pt_walk_pkg::*;
#(
  parameter int FRAME_W  = 20,
  parameter int ENT_W    = 32,
  parameter int PRES_BIT = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               mem_req_ready_i,
  input  logic               mem_rsp_valid_i,
  input  logic [ENT_W-1:0]   mem_rsp_data_i,
  output walk_state_e        state_o,
  output logic [FRAME_W-1:0] table_frame_o,
  output logic [FRAME_W-1:0] leaf_frame_o,
  output logic               fault_o,
  output logic               level_o
);
  walk_state_e        state_q;
  logic [FRAME_W-1:0] table_frame_q;
  logic [FRAME_W-1:0] leaf_frame_q;
  logic               fault_q;
  logic               level_q;
  logic               present;
  logic [FRAME_W-1:0] ent_frame;
  logic               unused_ent_bits;

  assign present         = mem_rsp_data_i[PRES_BIT];
  assign ent_frame       = mem_rsp_data_i[ENT_W-1 -: FRAME_W];
  assign unused_ent_bits = ^mem_rsp_data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      table_frame_q <= '0;
      leaf_frame_q  <= '0;
      fault_q       <= 1'b0;
      level_q       <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RD1;
            fault_q <= 1'b0;
            level_q <= 1'b0;
          end
        end
        ST_RD1: begin
          if (mem_req_ready_i) state_q <= ST_WT1;
        end
        ST_WT1: begin
          if (mem_rsp_valid_i) begin
            if (present) begin
              table_frame_q <= ent_frame;
              state_q       <= ST_RD2;
            end else begin
              fault_q <= 1'b1;
              level_q <= 1'b0;
              state_q <= ST_FIN;
            end
          end
        end
        ST_RD2: begin
          if (mem_req_ready_i) state_q <= ST_WT2;
        end
        ST_WT2: begin
          if (mem_rsp_valid_i) begin
            if (present) begin
              leaf_frame_q <= ent_frame;
            end else begin
              fault_q <= 1'b1;
              level_q <= 1'b1;
            end
            state_q <= ST_FIN;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o       = state_q;
  assign table_frame_o = table_frame_q;
  assign leaf_frame_o  = leaf_frame_q;
  assign fault_o       = fault_q;
  assign level_o       = level_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int IDX_W    = 10,
  parameter int OFF_W    = 12,
  parameter int FRAME_W  = 20,
  parameter int ENT_W    = 32,
  parameter int PRES_BIT = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [LEVELS*IDX_W+OFF_W-1:0] req_vaddr,
  input  logic [FRAME_W-1:0]       req_root,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic [FRAME_W+OFF_W-1:0] mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [ENT_W-1:0]         mem_rsp_data,
  output logic                     done_valid,
  output logic [FRAME_W+OFF_W-1:0] done_paddr,
  output logic                     done_fault,
  output logic                     done_level
);
  localparam int VA_W     = LEVELS * IDX_W + OFF_W;
  localparam int PA_W     = FRAME_W + OFF_W;
  localparam int ENT_LOG2 = $clog2(ENT_W / 8);

  walk_state_e        state;
  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] table_frame;
  logic [FRAME_W-1:0] leaf_frame;
  logic               accept;

  logic [FRAME_W-1:0] lvl_frame [LEVELS];
  logic [IDX_W-1:0]   lvl_idx   [LEVELS];
  logic [PA_W-1:0]    lvl_addr  [LEVELS];

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q   <= '0;
      root_q <= '0;
    end else if (accept) begin
      va_q   <= req_vaddr;
      root_q <= req_root;
    end
  end

  pt_walk_fsm #(
    .FRAME_W (FRAME_W),
    .ENT_W   (ENT_W),
    .PRES_BIT(PRES_BIT)
  ) i_fsm (
    .clk            (clk),
    .rst            (rst),
    .start_i        (accept),
    .mem_req_ready_i(mem_req_ready),
    .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i (mem_rsp_data),
    .state_o        (state),
    .table_frame_o  (table_frame),
    .leaf_frame_o   (leaf_frame),
    .fault_o        (done_fault),
    .level_o        (done_level)
  );

  // One address unit per table level; level 0 uses the captured base.
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    if (g == 0) begin : g_top
      assign lvl_frame[g] = root_q;
    end else begin : g_sub
      assign lvl_frame[g] = table_frame;
    end
    assign lvl_idx[g] = va_q[VA_W-1-g*IDX_W -: IDX_W];

    pt_entry_addr #(
      .FRAME_W (FRAME_W),
      .IDX_W   (IDX_W),
      .OFF_W   (OFF_W),
      .ENT_LOG2(ENT_LOG2)
    ) i_addr (
      .frame_i(lvl_frame[g]),
      .idx_i  (lvl_idx[g]),
      .addr_o (lvl_addr[g])
    );
  end

  assign mem_req_valid = (state == ST_RD1) || (state == ST_RD2);
  assign mem_req_addr  = (state == ST_RD2) ? lvl_addr[1] : lvl_addr[0];
  assign done_valid    = (state == ST_FIN);
  assign done_paddr    = {leaf_frame, va_q[OFF_W-1:0]};

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            done_valid,
  input logic            done_fault,
  input logic            done_level
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !mem_req_valid && !done_valid));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  assert_done_after_rsp_R9: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(mem_rsp_valid));

  assert_no_level_on_ok_R4: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !done_fault) |-> !done_level);

endmodule

bind pt_walker pt_walker_chk #(.PA_W(FRAME_W + OFF_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .done_valid   (done_valid),
  .done_fault   (done_fault),
  .done_level   (done_level)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [19:0] req_root;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done_valid;
  logic [31:0] done_paddr;
  logic        done_fault;
  logic        done_level;

  always #10 clk = ~clk;  // 50 MHz

  pt_walker i_pt_walker (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .req_root     (req_root),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .done_valid   (done_valid),
    .done_paddr   (done_paddr),
    .done_fault   (done_fault),
    .done_level   (done_level)
  );

  typedef struct {
    logic [31:0] paddr;
    logic        fault;
    logic        level;
    string       tag;
  } res_t;

  typedef struct {
    logic [31:0] addr;
    string       tag;
  } rd_t;

  res_t        res_q[$];
  rd_t         rd_q[$];
  logic [31:0] mem [logic [31:0]];
  int          checks = 0;
  int          fails  = 0;
  int          stall_n = 0;
  int          lat_n   = 0;

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: compute expected reads and result, then issue the request.
  task automatic walk(input logic [31:0] va, input logic [19:0] root, input string tag);
    logic [31:0] a1, a2, e1, e2;
    res_t r;
    rd_t  d;
    a1 = {root, 12'h000} + {20'h0, va[31:22], 2'b00};
    d.addr = a1; d.tag = {"R2 ", tag}; rd_q.push_back(d);
    e1 = rd_word(a1);
    r.tag = tag; r.paddr = 32'h0; r.level = 1'b0;
    if (!e1[0]) begin
      r.fault = 1'b1;                       // R5
    end else begin
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      d.addr = a2; d.tag = {"R3 ", tag}; rd_q.push_back(d);
      e2 = rd_word(a2);
      if (!e2[0]) begin
        r.fault = 1'b1; r.level = 1'b1;     // R6
      end else begin
        r.fault = 1'b0;                     // R4
        r.paddr = {e2[31:12], va[11:0]};
      end
    end
    res_q.push_back(r);

    @(negedge clk);
    check(req_ready == 1'b1, "R7 idle ready", {31'h0, req_ready}, 32'h1);
    req_vaddr = va; req_root = root; req_valid = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b0, "R7 busy", {31'h0, req_ready}, 32'h0);
    req_vaddr = ~va; req_root = ~root;      // ignored while busy
    @(negedge clk);
    check(req_ready == 1'b0, "R7 busy", {31'h0, req_ready}, 32'h0);
    req_valid = 1'b0;
    wait (res_q.size() == 0);
    @(negedge clk);
    check(done_valid == 1'b0, "R9 single pulse", {31'h0, done_valid}, 32'h0);
    stall_n = (stall_n + 1) % 3;
    lat_n   = (lat_n + 3) % 4;
  endtask

  // Memory responder with variable stall and response delay.
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
    forever begin
      @(negedge clk);
      if (!rst && mem_req_valid) begin
        logic [31:0] a;
        rd_t         e;
        a = mem_req_addr;
        for (int s = 0; s < stall_n; s++) begin
          @(negedge clk);
          check(mem_req_valid && mem_req_addr == a, "R8 hold", mem_req_addr, a);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (rd_q.size() == 0) begin
          check(1'b0, "R5 unexpected read", a, 32'h0);
        end else begin
          e = rd_q.pop_front();
          check(a == e.addr, e.tag, a, e.addr);
        end
        for (int l = 0; l < lat_n; l++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd_word(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // Monitor: compare each result strobe against the scoreboard.
  always @(negedge clk) begin
    if (!rst && done_valid) begin
      if (res_q.size() == 0) begin
        check(1'b0, "R9 unexpected result", done_paddr, 32'h0);
      end else begin
        res_t r;
        r = res_q.pop_front();
        check(rd_q.size() == 0, {"R5 reads left ", r.tag}, rd_q.size(), 32'h0);
        check(done_fault == r.fault, {"fault ", r.tag}, {31'h0, done_fault}, {31'h0, r.fault});
        check(done_level == r.level, {"level ", r.tag}, {31'h0, done_level}, {31'h0, r.level});
        if (!r.fault)
          check(done_paddr == r.paddr, {"paddr ", r.tag}, done_paddr, r.paddr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_root = '0;
    // Tables: base frame 0x00010 and 0x00011
    mem[32'h0001_0004] = 32'h0002_0001;   // top entry 1 -> table 0x20
    mem[32'h0002_000C] = 32'h00AB_CFFF;   // entry 3, stray bits 11:1 set
    mem[32'h0001_0FFC] = 32'h0003_0001;   // top entry 1023 -> table 0x30
    mem[32'h0003_0FFC] = 32'hFFFF_F001;   // entry 1023 -> frame 0xFFFFF
    mem[32'h0001_1004] = 32'h0004_0001;   // second base, entry 1 -> table 0x40
    mem[32'h0004_000C] = 32'h1234_5001;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", {31'h0, req_ready}, 32'h1);
    check(mem_req_valid == 1'b0, "R1 mem_req", {31'h0, mem_req_valid}, 32'h0);
    check(done_valid == 1'b0, "R1 done", {31'h0, done_valid}, 32'h0);

    for (int r = 0; r < 3; r++) begin
      walk(32'h0040_3004, 20'h00010, "R10 R4 example");
      walk(32'h0000_0123, 20'h00010, "R5 top fault");
      walk(32'h0040_4FFF, 20'h00010, "R6 second fault");
      walk(32'hFFFF_F7FF, 20'h00010, "R4 top indices");
      walk(32'h0040_3004, 20'h00011, "R2 other base");
      walk(32'h0040_3ABC, 20'h00010, "R7 R4 offset");
    end

    repeat (5) @(negedge clk);
    check(res_q.size() == 0, "R9 missing result", res_q.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule